// File: doc/BRIEF.md
# Delay Reconfiguration Sequencer

This block holds the run-time delay settings of a parallel source-synchronous interface and sequences every change made to them. It keeps per-pin transmit delays and per-pin receive strobe phase shifts for both strobe edges. Per nibble it keeps a receive-enable delay, a reference-voltage code and a read-leveling feedback counter. Per lane it keeps a receive FIFO read offset, a read-leveling mode bit and a differential-pair mode bit. The analog circuits that consume these values are outside the block. They see only the registered outputs.

A host issues one write at a time through an address/data port. Each accepted write runs inside a fixed wrapper. The wrapper raises the internal-clocks enable, pulses the training reset, applies the write, and then drops the clocks enable and pulses `done`. Writes presented while the wrapper is running are dropped. When a lane is in differential mode, transmit delay writes reach both pins of a pair, while receive phase writes reach only the even pin.

Top module: `dly_reconfig_seq`

## Requirements
- R1: After reset, every setting, every feedback counter, `clk_en`, `train_rst`, `busy` and `done` are 0.
- R2: The write accepted at a clock edge starts the wrapper. From the next cycle, `clk_en` and `busy` are high for four cycles. `train_rst` is high only in the second of those four cycles.
- R3: The target setting takes its new value at the edge that ends the fourth wrapper cycle. A setting output never changes unless `clk_en` was high and `train_rst` was low in the cycle before.
- R4: In the cycle after the wrapper, `done` is high for exactly one cycle, with `clk_en` and `busy` both low. A new write is accepted while `idle` or `done` is asserted.
- R5: A write presented while `busy` is high has no effect on any setting and does not restart the wrapper.
- R6: The address is {kind[2:0], index[3:0]}. The kinds are:
  - 0: transmit delay per pin, 11 bits
  - 1: positive-edge phase per pin, 7 bits
  - 2: negative-edge phase per pin, 7 bits
  - 3: receive-enable delay per nibble, 11 bits
  - 4: reference code per nibble, 9 bits
  - 5: read offset per lane, 4 bits
  - 6: read-leveling mode per lane, 1 bit
  - 7: differential mode per lane, 1 bit

  Each field takes the low bits of `wr_data`. Pins are grouped four to a nibble and eight to a lane.
- R7: With its lane in differential mode, a transmit delay write to either pin of pair {2k, 2k+1} sets both pins.
- R8: With its lane in differential mode, a positive- or negative-edge phase write to an odd pin is dropped. A write to the even pin sets the even pin only.
- R9: A nibble or lane write whose index is beyond the number of nibbles or lanes changes nothing.
- R10: When a nibble's lane has read-leveling mode set, that nibble's 12-bit feedback counter adds one for each cycle its `fb_tick` bit is high. With the mode clear, the counter holds.
- R11: Every training reset pulse clears all feedback counters to 0.
- R12: A feedback counter stops at 4095 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write request |
| wr_addr | input | 7 | {kind, index} |
| wr_data | input | 11 | Write value, low bits used |
| fb_tick | input | 4 | Per-nibble feedback events |
| busy | output | 1 | Wrapper running |
| done | output | 1 | One-cycle completion pulse |
| clk_en | output | 1 | Internal-clocks enable |
| train_rst | output | 1 | Training reset pulse |
| tx_delay | output | 176 | Transmit delay, 11 bits per pin |
| rx_pos_phase | output | 112 | Positive-edge phase, 7 bits per pin |
| rx_neg_phase | output | 112 | Negative-edge phase, 7 bits per pin |
| rcv_en_delay | output | 44 | Receive-enable delay, 11 bits per nibble |
| vref_code | output | 36 | Reference code, 9 bits per nibble |
| rd_ofs | output | 8 | Read offset, 4 bits per lane |
| rl_mode | output | 2 | Read-leveling mode per lane |
| diff_mode | output | 2 | Differential mode per lane |
| fb_count | output | 48 | Feedback counter, 12 bits per nibble |

## Verification
The wrapper is first exercised with directed writes. Each phase of the wrapper is sampled, which separates a correct order from a reordered, shortened or lengthened one. Back-to-back writes are issued from the `done` cycle, and rejected writes are injected mid-wrapper. Together these distinguish correct busy gating from a restart or a late apply. A random mix of all eight kinds, of in-range and out-of-range indices and of toggled differential modes is then compared against a field model. This mix tells apart pair mirroring, odd-pin suppression and index bounds. Feedback ticks are driven with the mode set in one lane and clear in the other, and run long enough to reach the ceiling. This separates counting, holding, clearing and saturation.

// File: rtl/dly_cfg_pkg.sv
package dly_cfg_pkg;

    localparam int KIND_W = 3;
    localparam int TX_W   = 11;
    localparam int PI_W   = 7;
    localparam int RCV_W  = 11;
    localparam int VREF_W = 9;
    localparam int OFS_W  = 4;
    localparam int FB_W   = 12;
    localparam int DATA_W = 11;

    typedef enum logic [KIND_W-1:0] {
        K_TXDLY = 3'd0,
        K_RXPOS = 3'd1,
        K_RXNEG = 3'd2,
        K_RCVEN = 3'd3,
        K_VREF  = 3'd4,
        K_RDOFS = 3'd5,
        K_RLMOD = 3'd6,
        K_DIFF  = 3'd7
    } set_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENABLE,
        S_TRST_HI,
        S_TRST_LO,
        S_APPLY,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/dly_seq_ctrl.sv
module dly_seq_ctrl
    import dly_cfg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clk_en,
    output logic              train_rst,
    output logic              busy,
    output logic              done,
    output logic              apply,
    output logic [ADDR_W-1:0] ap_addr,
    output logic [DATA_W-1:0] ap_data
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            S_IDLE, S_DONE: begin
                if (wr_en) begin
                    ctrl_d.st   = S_ENABLE;
                    ctrl_d.addr = wr_addr;
                    ctrl_d.data = wr_data;
                end else begin
                    ctrl_d.st = S_IDLE;
                end
            end
            S_ENABLE:  ctrl_d.st = S_TRST_HI;
            S_TRST_HI: ctrl_d.st = S_TRST_LO;
            S_TRST_LO: ctrl_d.st = S_APPLY;
            S_APPLY:   ctrl_d.st = S_DONE;
            default:   ctrl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: S_IDLE, addr: '0, data: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy      = (ctrl_q.st == S_ENABLE) || (ctrl_q.st == S_TRST_HI) ||
                       (ctrl_q.st == S_TRST_LO) || (ctrl_q.st == S_APPLY);
    assign clk_en    = busy;
    assign train_rst = (ctrl_q.st == S_TRST_HI);
    assign apply     = (ctrl_q.st == S_APPLY);
    assign done      = (ctrl_q.st == S_DONE);
    assign ap_addr   = ctrl_q.addr;
    assign ap_data   = ctrl_q.data;

endmodule

// File: rtl/dly_pin_bank.sv
module dly_pin_bank
    import dly_cfg_pkg::*;
#(
    parameter int NUM_PINS      = 16,
    parameter int PINS_PER_LANE = 8,
    parameter int NUM_LANES     = 2,
    parameter int IDX_W         = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply,
    input  logic [KIND_W-1:0]        kind,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        data,
    input  logic [NUM_LANES-1:0]     diff_mode,
    output logic [NUM_PINS*TX_W-1:0] tx_flat,
    output logic [NUM_PINS*PI_W-1:0] rxp_flat,
    output logic [NUM_PINS*PI_W-1:0] rxn_flat
);

    typedef struct packed {
        logic [TX_W-1:0] tx;
        logic [PI_W-1:0] rxp;
        logic [PI_W-1:0] rxn;
    } pin_t;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int LANE = p / PINS_PER_LANE;
        localparam int MATE = p ^ 1;
        localparam bit ODD  = (p % 2) == 1;

        pin_t pin_d, pin_q;
        logic hit_self, hit_mate, rx_ok;

        always_comb begin
            hit_self = (idx == IDX_W'(p));
            hit_mate = diff_mode[LANE] && (idx == IDX_W'(MATE));
            rx_ok    = hit_self && !(diff_mode[LANE] && ODD);
            pin_d    = pin_q;
            if (apply) begin
                if (kind == K_TXDLY && (hit_self || hit_mate)) pin_d.tx  = data[TX_W-1:0];
                if (kind == K_RXPOS && rx_ok)                  pin_d.rxp = data[PI_W-1:0];
                if (kind == K_RXNEG && rx_ok)                  pin_d.rxn = data[PI_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= '0;
            else        pin_q <= pin_d;
        end

        assign tx_flat[p*TX_W +: TX_W]  = pin_q.tx;
        assign rxp_flat[p*PI_W +: PI_W] = pin_q.rxp;
        assign rxn_flat[p*PI_W +: PI_W] = pin_q.rxn;
    end

endmodule

// File: rtl/dly_grp_bank.sv
module dly_grp_bank
    import dly_cfg_pkg::*;
#(
    parameter int NUM_NIBS      = 4,
    parameter int NIBS_PER_LANE = 2,
    parameter int NUM_LANES     = 2,
    parameter int IDX_W         = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        apply,
    input  logic [KIND_W-1:0]           kind,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           data,
    input  logic                        train_rst,
    input  logic [NUM_NIBS-1:0]         fb_tick,
    output logic [NUM_NIBS*RCV_W-1:0]   rcv_flat,
    output logic [NUM_NIBS*VREF_W-1:0]  vref_flat,
    output logic [NUM_NIBS*FB_W-1:0]    fb_flat,
    output logic [NUM_LANES*OFS_W-1:0]  ofs_flat,
    output logic [NUM_LANES-1:0]        rl_mode,
    output logic [NUM_LANES-1:0]        diff_mode
);

    typedef struct packed {
        logic [RCV_W-1:0]  rcv;
        logic [VREF_W-1:0] vref;
        logic [FB_W-1:0]   fb;
    } nib_t;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             rl;
        logic             diff;
    } lane_t;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_t lane_d, lane_q;
        logic  hit;

        always_comb begin
            hit    = apply && (idx == IDX_W'(l));
            lane_d = lane_q;
            if (hit && kind == K_RDOFS) lane_d.ofs  = data[OFS_W-1:0];
            if (hit && kind == K_RLMOD) lane_d.rl   = data[0];
            if (hit && kind == K_DIFF)  lane_d.diff = data[0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign ofs_flat[l*OFS_W +: OFS_W] = lane_q.ofs;
        assign rl_mode[l]                 = lane_q.rl;
        assign diff_mode[l]               = lane_q.diff;
    end

    for (genvar n = 0; n < NUM_NIBS; n++) begin : g_nib
        localparam int LANE = n / NIBS_PER_LANE;

        nib_t nib_d, nib_q;
        logic hit;

        always_comb begin
            hit   = apply && (idx == IDX_W'(n));
            nib_d = nib_q;
            if (hit && kind == K_RCVEN) nib_d.rcv  = data[RCV_W-1:0];
            if (hit && kind == K_VREF)  nib_d.vref = data[VREF_W-1:0];
            if (train_rst) begin
                nib_d.fb = '0;
            end else if (rl_mode[LANE] && fb_tick[n] && (nib_q.fb != '1)) begin
                nib_d.fb = nib_q.fb + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nib_q <= '0;
            else        nib_q <= nib_d;
        end

        assign rcv_flat[n*RCV_W +: RCV_W]    = nib_q.rcv;
        assign vref_flat[n*VREF_W +: VREF_W] = nib_q.vref;
        assign fb_flat[n*FB_W +: FB_W]       = nib_q.fb;
    end

endmodule

// File: rtl/dly_reconfig_seq.sv
module dly_reconfig_seq
    import dly_cfg_pkg::*;
#(
    parameter int PINS_PER_NIB  = 4,
    parameter int NIBS_PER_LANE = 2,
    parameter int NUM_LANES     = 2,
    localparam int NUM_NIBS     = NIBS_PER_LANE * NUM_LANES,
    localparam int NUM_PINS     = PINS_PER_NIB * NUM_NIBS,
    localparam int IDX_W        = $clog2(NUM_PINS),
    localparam int ADDR_W       = KIND_W + IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NUM_NIBS-1:0]         fb_tick,
    output logic                        busy,
    output logic                        done,
    output logic                        clk_en,
    output logic                        train_rst,
    output logic [NUM_PINS*TX_W-1:0]    tx_delay,
    output logic [NUM_PINS*PI_W-1:0]    rx_pos_phase,
    output logic [NUM_PINS*PI_W-1:0]    rx_neg_phase,
    output logic [NUM_NIBS*RCV_W-1:0]   rcv_en_delay,
    output logic [NUM_NIBS*VREF_W-1:0]  vref_code,
    output logic [NUM_LANES*OFS_W-1:0]  rd_ofs,
    output logic [NUM_LANES-1:0]        rl_mode,
    output logic [NUM_LANES-1:0]        diff_mode,
    output logic [NUM_NIBS*FB_W-1:0]    fb_count
);

    logic              apply;
    logic [ADDR_W-1:0] ap_addr;
    logic [DATA_W-1:0] ap_data;
    logic [KIND_W-1:0] ap_kind;
    logic [IDX_W-1:0]  ap_idx;

    assign ap_kind = ap_addr[ADDR_W-1 -: KIND_W];
    assign ap_idx  = ap_addr[IDX_W-1:0];

    dly_seq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .clk_en    (clk_en),
        .train_rst (train_rst),
        .busy      (busy),
        .done      (done),
        .apply     (apply),
        .ap_addr   (ap_addr),
        .ap_data   (ap_data)
    );

    dly_pin_bank #(
        .NUM_PINS      (NUM_PINS),
        .PINS_PER_LANE (PINS_PER_NIB * NIBS_PER_LANE),
        .NUM_LANES     (NUM_LANES),
        .IDX_W         (IDX_W)
    ) pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .kind      (ap_kind),
        .idx       (ap_idx),
        .data      (ap_data),
        .diff_mode (diff_mode),
        .tx_flat   (tx_delay),
        .rxp_flat  (rx_pos_phase),
        .rxn_flat  (rx_neg_phase)
    );

    dly_grp_bank #(
        .NUM_NIBS      (NUM_NIBS),
        .NIBS_PER_LANE (NIBS_PER_LANE),
        .NUM_LANES     (NUM_LANES),
        .IDX_W         (IDX_W)
    ) grp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .kind      (ap_kind),
        .idx       (ap_idx),
        .data      (ap_data),
        .train_rst (train_rst),
        .fb_tick   (fb_tick),
        .rcv_flat  (rcv_en_delay),
        .vref_flat (vref_code),
        .fb_flat   (fb_count),
        .ofs_flat  (rd_ofs),
        .rl_mode   (rl_mode),
        .diff_mode (diff_mode)
    );

endmodule

// File: rtl/dly_reconfig_seq_chk.sv
module dly_reconfig_seq_chk #(
    parameter int TXF_W = 176,
    parameter int RXF_W = 112,
    parameter int FBF_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             busy,
    input logic             done,
    input logic             clk_en,
    input logic             train_rst,
    input logic [TXF_W-1:0] tx_delay,
    input logic [RXF_W-1:0] rx_pos_phase,
    input logic [FBF_W-1:0] fb_count
);

    // R2
    trst_in_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_rst |-> clk_en);

    // R2
    trst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_rst |=> !train_rst);

    // R2
    clk_before_trst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_rst) |-> $past(clk_en));

    // R3
    tx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_delay) |-> ($past(clk_en) && !$past(train_rst)));

    // R3
    rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_pos_phase) |-> ($past(clk_en) && !$past(train_rst)));

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!clk_en && !busy));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (busy || done));

    // R11
    fb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_rst |=> (fb_count == '0));

endmodule

bind dly_reconfig_seq dly_reconfig_seq_chk #(
    .TXF_W (NUM_PINS * dly_cfg_pkg::TX_W),
    .RXF_W (NUM_PINS * dly_cfg_pkg::PI_W),
    .FBF_W (NUM_NIBS * dly_cfg_pkg::FB_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .busy         (busy),
    .done         (done),
    .clk_en       (clk_en),
    .train_rst    (train_rst),
    .tx_delay     (tx_delay),
    .rx_pos_phase (rx_pos_phase),
    .fb_count     (fb_count)
);

// File: tb/dly_reconfig_seq_tb.sv
module dly_reconfig_seq_tb_top;

    localparam int NP = 16;
    localparam int NN = 4;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [10:0]   wr_data = '0;
    logic [NN-1:0] fb_tick = '0;
    logic          busy, done, clk_en, train_rst;
    logic [NP*11-1:0] tx_delay;
    logic [NP*7-1:0]  rx_pos_phase, rx_neg_phase;
    logic [NN*11-1:0] rcv_en_delay;
    logic [NN*9-1:0]  vref_code;
    logic [NL*4-1:0]  rd_ofs;
    logic [NL-1:0]    rl_mode, diff_mode;
    logic [NN*12-1:0] fb_count;

    always #2 clk = ~clk;

    dly_reconfig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fb_tick(fb_tick), .busy(busy), .done(done),
        .clk_en(clk_en), .train_rst(train_rst), .tx_delay(tx_delay),
        .rx_pos_phase(rx_pos_phase), .rx_neg_phase(rx_neg_phase),
        .rcv_en_delay(rcv_en_delay), .vref_code(vref_code), .rd_ofs(rd_ofs),
        .rl_mode(rl_mode), .diff_mode(diff_mode), .fb_count(fb_count)
    );

    int n_run = 0;
    int n_fail = 0;

    int m_tx[NP], m_rp[NP], m_rn[NP];
    int m_rcv[NN], m_vref[NN], m_fb[NN];
    int m_ofs[NL], m_rl[NL], m_diff[NL];

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lane_of_pin(int p);
        return p / 8;
    endfunction

    // Model of one applied write (R6..R9)
    task automatic model_write(int kind, int idx, int data);
        case (kind)
            0: if (idx < NP) begin
                   m_tx[idx] = data & 11'h7ff;
                   if (m_diff[lane_of_pin(idx)] != 0) m_tx[idx ^ 1] = data & 11'h7ff;
               end
            1, 2: if (idx < NP && !(m_diff[lane_of_pin(idx)] != 0 && (idx % 2) == 1)) begin
                   if (kind == 1) m_rp[idx] = data & 7'h7f;
                   else           m_rn[idx] = data & 7'h7f;
               end
            3: if (idx < NN) m_rcv[idx] = data & 11'h7ff;
            4: if (idx < NN) m_vref[idx] = data & 9'h1ff;
            5: if (idx < NL) m_ofs[idx] = data & 4'hf;
            6: if (idx < NL) m_rl[idx] = data & 1;
            7: if (idx < NL) m_diff[idx] = data & 1;
            default: ;
        endcase
    endtask

    task automatic check_all(string req);
        for (int p = 0; p < NP; p++) begin
            chk(req, $sformatf("tx[%0d]", p), int'(tx_delay[p*11 +: 11]), m_tx[p]);
            chk(req, $sformatf("rxp[%0d]", p), int'(rx_pos_phase[p*7 +: 7]), m_rp[p]);
            chk(req, $sformatf("rxn[%0d]", p), int'(rx_neg_phase[p*7 +: 7]), m_rn[p]);
        end
        for (int n = 0; n < NN; n++) begin
            chk(req, $sformatf("rcv[%0d]", n), int'(rcv_en_delay[n*11 +: 11]), m_rcv[n]);
            chk(req, $sformatf("vref[%0d]", n), int'(vref_code[n*9 +: 9]), m_vref[n]);
            chk(req, $sformatf("fb[%0d]", n), int'(fb_count[n*12 +: 12]), m_fb[n]);
        end
        for (int l = 0; l < NL; l++) begin
            chk(req, $sformatf("ofs[%0d]", l), int'(rd_ofs[l*4 +: 4]), m_ofs[l]);
            chk(req, $sformatf("rl[%0d]", l), int'(rl_mode[l]), m_rl[l]);
            chk(req, $sformatf("diff[%0d]", l), int'(diff_mode[l]), m_diff[l]);
        end
    endtask

    // Issues one write at a negedge; returns at the negedge of the done cycle.
    task automatic do_write(int kind, int idx, int data, bit inject);
        wr_en = 1'b1; wr_addr = 7'((kind << 4) | idx); wr_data = 11'(data);
        @(negedge clk);
        if (inject) begin
            wr_addr = 7'(((kind + 1) % 8 << 4) | (idx ^ 3));
            wr_data = 11'(~data);
        end else wr_en = 1'b0;
        chk("R2", "enable clk_en", int'(clk_en), 1);
        chk("R2", "enable busy", int'(busy), 1);
        chk("R2", "enable trst", int'(train_rst), 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2", "pulse trst", int'(train_rst), 1);
        chk("R2", "pulse clk_en", int'(clk_en), 1);
        for (int n = 0; n < NN; n++) m_fb[n] = 0;
        @(negedge clk);
        chk("R2", "trst low", int'(train_rst), 0);
        chk("R5", "busy mid", int'(busy), 1);
        chk("R11", "fb cleared", int'(fb_count), 0);
        @(negedge clk);
        chk("R2", "apply clk_en", int'(clk_en), 1);
        chk("R3", "no early apply", int'(done), 0);
        @(negedge clk);
        model_write(kind, idx, data);
        chk("R4", "done", int'(done), 1);
        chk("R4", "clk_en off", int'(clk_en), 0);
        chk("R4", "busy off", int'(busy), 0);
        check_all(inject ? "R5" : "R3");
    endtask

    task automatic tick_cycles(int cnt, logic [NN-1:0] pat);
        for (int i = 0; i < cnt; i++) begin
            fb_tick = pat;
            @(negedge clk);
            for (int n = 0; n < NN; n++)
                if (pat[n] && m_rl[n / 2] != 0 && m_fb[n] < 4095) m_fb[n]++;
        end
        fb_tick = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < NP; p++) begin m_tx[p] = 0; m_rp[p] = 0; m_rn[p] = 0; end
        for (int n = 0; n < NN; n++) begin m_rcv[n] = 0; m_vref[n] = 0; m_fb[n] = 0; end
        for (int l = 0; l < NL; l++) begin m_ofs[l] = 0; m_rl[l] = 0; m_diff[l] = 0; end

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "clk_en", int'(clk_en), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "trst", int'(train_rst), 0);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R6 every kind once, field truncation to low bits
        do_write(0, 5, 11'h5a5, 0);
        do_write(1, 5, 11'h7ff, 0);
        do_write(2, 6, 11'h0c3, 0);
        do_write(3, 2, 11'h6e1, 0);
        do_write(4, 3, 11'h7ff, 0);
        do_write(5, 1, 11'h0fd, 0);
        do_write(7, 0, 1, 0);
        @(negedge clk);
        chk("R4", "done single cycle", int'(done), 0);

        // R7 differential mirror of output delay
        do_write(0, 3, 321, 0);
        chk("R7", "pair pin2", int'(tx_delay[2*11 +: 11]), 321);
        // R8 odd-pin input delay suppressed, even pin only
        do_write(1, 3, 99, 0);
        chk("R8", "odd rxp kept", int'(rx_pos_phase[3*7 +: 7]), 0);
        do_write(2, 2, 77, 0);
        chk("R8", "odd rxn untouched", int'(rx_neg_phase[3*7 +: 7]), 0);
        // R9 out-of-range nibble/lane index
        do_write(3, 9, 500, 0);
        do_write(5, 4, 7, 0);
        // R5 rejected writes mid-wrapper
        do_write(4, 0, 200, 1);
        do_write(0, 12, 1000, 1);

        // R10 counting / holding, R11 clear, R12 saturation
        do_write(6, 0, 1, 0);
        tick_cycles(37, 4'b0111);
        check_all("R10");
        do_write(6, 1, 1, 0);
        check_all("R11");
        tick_cycles(4105, 4'b0100);
        chk("R12", "fb sat", int'(fb_count[2*12 +: 12]), 4095);
        check_all("R12");

        // Random mix, back-to-back from the done cycle
        for (int i = 0; i < 160; i++) begin
            int k, x, d;
            k = int'($urandom % 8);
            x = int'($urandom % 16);
            d = int'($urandom % 2048);
            do_write(k, x, d, ($urandom % 4) == 0);
            if ((i % 16) == 0) tick_cycles(5, 4'($urandom));
        end
        check_all("R6");

        finish_run();
    end

endmodule